// File: doc/BRIEF.md
# CPU Address Window Decoder with Register Forwarding

This block sits between an 8-bit CPU with a 16-bit address bus and the rest of a small console-style system. It splits the address space into four windows. The low window is a 2 KB work RAM, repeated across the whole low eighth of the map. The next window is a bank of eight video-controller registers, repeated every eight bytes. Above that sits a short bank of I/O registers. Everything from 0x4020 upward belongs to an external cartridge. The block keeps local copies of every register that is written, so the CPU can read back any register value, including registers that are write-only at the peripheral.

Writes to the video registers, and to three chosen I/O registers, are forwarded to a remote peripheral. Each forwarded write becomes a two-byte message on a ready/valid byte port. The first byte is the register's low address byte and the second is the written value. A serial shifter is expected to sit on that port. One further forwarded write can wait in a single-entry queue while a message is in flight. If a second write is already waiting, the CPU is stalled. The block also drives the vertical-blank interrupt request from an enable bit in video register 0 and an external blanking input.

Top module: `bus_window_decoder`

## Requirements
- R1: Addresses 0x0000–0x1FFF access a RAM indexed by address bits [10:0]. The stack page gets no special handling. Read data appears on `cpu_rdata` in the cycle after the read request, and a write is visible to a read issued in the next cycle.
- R2: Addresses 0x2000–0x3FFF access eight video registers indexed by address bits [2:0]. A read returns the last value written to that index, or 0x00 if nothing has been written since reset.
- R3: Addresses 0x4000–0x4017 access 24 I/O registers indexed by address bits [4:0]. A read returns the last value written, or 0x00 if nothing has been written since reset.
- R4: Addresses 0x4018–0x401F hold no storage. Writes there have no effect and reads return 0x00.
- R5: For addresses at or above 0x4020, `cart_sel` is high in the request cycle and `cart_we` follows the write strobe. `cart_addr` always equals `cpu_addr`. A cartridge read returns the `cart_rdata` value present in the following cycle.
- R6: A forwarded write produces two bytes on `tx_data`. The first is the register's low address byte: 0x00–0x07 for video registers, or 0x14/0x16/0x17. The second is the written value. `tx_valid` rises in the cycle after an accepted write when no message is in flight. A byte stays on `tx_data` until `tx_ready` is seen.
- R7: All video-register writes are forwarded. Among the I/O registers only offsets 0x14, 0x16 and 0x17 are forwarded. The other I/O registers and the RAM are only stored, and cartridge writes produce no message.
- R8: One forwarded write may wait behind the message in flight, and messages leave in write order. `cpu_stall` is high exactly while two forwarded messages are not yet fully sent.
- R9: While `cpu_stall` is high, reads and writes are ignored entirely: no store, no forwarding, no cartridge select, no read data.
- R10: `nmi_out` is high in exactly the cycles where bit 7 of video register 0 is set and `blank_in` is high.
- R11: After reset, `tx_valid`, `cpu_stall` and `nmi_out` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wr | input | 1 | Write strobe; takes priority over `cpu_rd` |
| cpu_rd | input | 1 | Read strobe |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data, valid the cycle after a read |
| cpu_stall | output | 1 | CPU must hold its request; request is ignored |
| cart_addr | output | 16 | Address to the cartridge |
| cart_sel | output | 1 | Cartridge access this cycle |
| cart_we | output | 1 | Cartridge write this cycle |
| cart_wdata | output | 8 | Cartridge write data |
| cart_rdata | input | 8 | Cartridge read data, sampled the cycle after the select |
| tx_valid | output | 1 | Forwarding byte available |
| tx_data | output | 8 | Forwarding byte |
| tx_ready | input | 1 | Shifter takes the byte this cycle |
| blank_in | input | 1 | Vertical blanking active |
| nmi_out | output | 1 | Vertical-blank interrupt request |

## Verification
The bench builds the block with its default parameters: a 2 KB RAM, eight video registers, 24 I/O registers and the interrupt enable in bit 7. With a 2 KB RAM, the mirror copies at 0x0800, 0x1000 and 0x1800 can be reached with a handful of addresses. Holding `tx_ready` low lets the in-flight message, the queued message and a stalled third write all exist at once. This exercises the stall and the rule that stalled requests are ignored. A random phase mixes every window, including the empty gap at 0x4018, with irregular `tx_ready` and `blank_in`. This exposes the cycle where a message finishes while a new forwarded write arrives.

// File: rtl/busdec_pkg.sv
package busdec_pkg;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;
    localparam int IO_OFF_W = 5;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] byte_t;

    localparam addr_t VID_BASE  = 16'h2000;
    localparam addr_t IO_BASE   = 16'h4000;
    localparam addr_t IO_LAST   = 16'h4017;
    localparam addr_t CART_BASE = 16'h4020;

    typedef enum logic [2:0] {
        RGN_RAM,
        RGN_VID,
        RGN_IO,
        RGN_HOLE,
        RGN_CART
    } region_e;

    typedef enum logic [1:0] {
        FS_IDLE,
        FS_TAG,
        FS_VAL
    } fwd_state_e;

    // accepted request after decode
    typedef struct packed {
        region_e rgn;
        logic    wr;
        logic    rd;
        logic    fwd;
    } busreq_t;

    // two-byte forwarding message
    typedef struct packed {
        byte_t tag;
        byte_t value;
    } fwd_msg_t;

    function automatic region_e classify(addr_t a);
        region_e r;
        if (a < VID_BASE)       r = RGN_RAM;
        else if (a < IO_BASE)   r = RGN_VID;
        else if (a <= IO_LAST)  r = RGN_IO;
        else if (a < CART_BASE) r = RGN_HOLE;
        else                    r = RGN_CART;
        return r;
    endfunction

    function automatic logic io_forwarded(logic [IO_OFF_W-1:0] off);
        return (off == 5'h14) || (off == 5'h16) || (off == 5'h17);
    endfunction

endpackage

// File: rtl/busdec_decode.sv
module busdec_decode
    import busdec_pkg::*;
(
    input  addr_t   addr,
    input  logic    wr,
    input  logic    rd,
    input  logic    stall,
    output busreq_t req
);

    logic    accept;
    region_e rgn;

    always_comb begin
        rgn      = classify(addr);
        accept   = (wr || rd) && !stall;
        req.rgn  = rgn;
        req.wr   = accept && wr;
        req.rd   = accept && rd && !wr;
        req.fwd  = (rgn == RGN_VID) ||
                   ((rgn == RGN_IO) && io_forwarded(addr[IO_OFF_W-1:0]));
    end

endmodule

// File: rtl/busdec_ram.sv
module busdec_ram
    import busdec_pkg::*;
#(
    parameter int AW = 11
) (
    input  logic          clk,
    input  logic          we,
    input  logic          re,
    input  logic [AW-1:0] addr,
    input  byte_t         wdata,
    output byte_t         rdata
);

    localparam int DEPTH = 1 << AW;

    byte_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
        if (re) rdata <= mem[addr];
    end

endmodule

// File: rtl/busdec_regs.sv
module busdec_regs
    import busdec_pkg::*;
#(
    parameter int VID_N = 8,
    parameter int IO_N  = 24
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     vid_we,
    input  logic                     vid_re,
    input  logic [$clog2(VID_N)-1:0] vid_idx,
    input  logic                     io_we,
    input  logic                     io_re,
    input  logic [IO_OFF_W-1:0]      io_idx,
    input  byte_t                    wdata,
    output byte_t                    rdata,
    output byte_t                    vid0
);

    byte_t vid_q [VID_N];
    byte_t io_q  [IO_N];

    for (genvar gi = 0; gi < VID_N; gi++) begin : g_vid
        always_ff @(posedge clk) begin
            if (rst)                                    vid_q[gi] <= '0;
            else if (vid_we && (int'(vid_idx) == gi))   vid_q[gi] <= wdata;
        end
    end

    for (genvar gj = 0; gj < IO_N; gj++) begin : g_io
        always_ff @(posedge clk) begin
            if (rst)                                  io_q[gj] <= '0;
            else if (io_we && (int'(io_idx) == gj))   io_q[gj] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)         rdata <= '0;
        else if (vid_re) rdata <= vid_q[vid_idx];
        else if (io_re)  rdata <= io_q[io_idx];
    end

    assign vid0 = vid_q[0];

    // R2: a video write followed by a read of the same index returns the value
    assert_vid_readback_R2: assert property (@(posedge clk) disable iff (rst)
        (vid_we && !io_we) ##1 (vid_re && $stable(vid_idx)) |=> (rdata == $past(wdata, 2)));

endmodule

// File: rtl/busdec_fwd.sv
module busdec_fwd
    import busdec_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     push,
    input  fwd_msg_t push_msg,
    output logic     stall,
    output logic     tx_valid,
    output byte_t    tx_data,
    input  logic     tx_ready
);

    fwd_state_e state_q;
    fwd_msg_t   cur_q;
    fwd_msg_t   pend_q;
    logic       pend_full_q;
    logic       hs;
    logic       done;

    assign tx_valid = (state_q != FS_IDLE);
    assign tx_data  = (state_q == FS_TAG) ? cur_q.tag : cur_q.value;
    assign stall    = pend_full_q;
    assign hs       = tx_valid && tx_ready;
    assign done     = (state_q == FS_VAL) && hs;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= FS_IDLE;
            cur_q       <= '0;
            pend_q      <= '0;
            pend_full_q <= 1'b0;
        end else begin
            unique case (state_q)
                FS_IDLE: begin
                    if (push) begin
                        cur_q   <= push_msg;
                        state_q <= FS_TAG;
                    end
                end
                FS_TAG: begin
                    if (hs) state_q <= FS_VAL;
                end
                FS_VAL: begin
                    if (hs) begin
                        if (pend_full_q) begin
                            cur_q       <= pend_q;
                            pend_full_q <= 1'b0;
                            state_q     <= FS_TAG;
                        end else if (push) begin
                            cur_q   <= push_msg;
                            state_q <= FS_TAG;
                        end else begin
                            state_q <= FS_IDLE;
                        end
                    end
                end
                default: state_q <= FS_IDLE;
            endcase
            if (push && (state_q != FS_IDLE) && !done) begin
                pend_q      <= push_msg;
                pend_full_q <= 1'b1;
            end
        end
    end

    // R6: a byte offered but not taken stays put
    assert_hold_byte_R6: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

    // R6: a write into an idle forwarder starts with its address byte
    assert_start_tag_R6: assert property (@(posedge clk) disable iff (rst)
        (push && !tx_valid) |=> (tx_valid && (tx_data == $past(push_msg.tag))));

    // R8: stall only while a message is on the port
    assert_stall_busy_R8: assert property (@(posedge clk) disable iff (rst)
        stall |-> tx_valid);

    // R9: no push is accepted while stalled
    assert_no_push_stalled_R9: assert property (@(posedge clk) disable iff (rst)
        stall |-> !push);

endmodule

// File: rtl/bus_window_decoder.sv
module bus_window_decoder
    import busdec_pkg::*;
#(
    parameter int RAM_AW  = 11,
    parameter int VID_N   = 8,
    parameter int IO_N    = 24,
    parameter int NMI_BIT = 7
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [15:0] cpu_addr,
    input  logic        cpu_wr,
    input  logic        cpu_rd,
    input  logic [7:0]  cpu_wdata,
    output logic [7:0]  cpu_rdata,
    output logic        cpu_stall,
    output logic [15:0] cart_addr,
    output logic        cart_sel,
    output logic        cart_we,
    output logic [7:0]  cart_wdata,
    input  logic [7:0]  cart_rdata,
    output logic        tx_valid,
    output logic [7:0]  tx_data,
    input  logic        tx_ready,
    input  logic        blank_in,
    output logic        nmi_out
);

    localparam int VID_IW = $clog2(VID_N);

    busreq_t  req;
    region_e  rd_src_q;
    byte_t    ram_rdata;
    byte_t    reg_rdata;
    byte_t    vid0;
    fwd_msg_t msg;
    logic     push;

    busdec_decode u_decode (
        .addr  (cpu_addr),
        .wr    (cpu_wr),
        .rd    (cpu_rd),
        .stall (cpu_stall),
        .req   (req)
    );

    busdec_ram #(.AW(RAM_AW)) u_ram (
        .clk   (clk),
        .we    (req.wr && (req.rgn == RGN_RAM)),
        .re    (req.rd && (req.rgn == RGN_RAM)),
        .addr  (cpu_addr[RAM_AW-1:0]),
        .wdata (cpu_wdata),
        .rdata (ram_rdata)
    );

    busdec_regs #(.VID_N(VID_N), .IO_N(IO_N)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .vid_we  (req.wr && (req.rgn == RGN_VID)),
        .vid_re  (req.rd && (req.rgn == RGN_VID)),
        .vid_idx (cpu_addr[VID_IW-1:0]),
        .io_we   (req.wr && (req.rgn == RGN_IO)),
        .io_re   (req.rd && (req.rgn == RGN_IO)),
        .io_idx  (cpu_addr[IO_OFF_W-1:0]),
        .wdata   (cpu_wdata),
        .rdata   (reg_rdata),
        .vid0    (vid0)
    );

    always_comb begin
        push      = req.wr && req.fwd;
        msg.tag   = (req.rgn == RGN_VID) ? byte_t'(cpu_addr[VID_IW-1:0]) : cpu_addr[7:0];
        msg.value = cpu_wdata;
    end

    busdec_fwd u_fwd (
        .clk      (clk),
        .rst      (rst),
        .push     (push),
        .push_msg (msg),
        .stall    (cpu_stall),
        .tx_valid (tx_valid),
        .tx_data  (tx_data),
        .tx_ready (tx_ready)
    );

    // source of the read data returned next cycle
    always_ff @(posedge clk) begin
        if (rst)         rd_src_q <= RGN_HOLE;
        else if (req.rd) rd_src_q <= req.rgn;
        else             rd_src_q <= RGN_HOLE;
    end

    always_comb begin
        unique case (rd_src_q)
            RGN_RAM:          cpu_rdata = ram_rdata;
            RGN_VID, RGN_IO:  cpu_rdata = reg_rdata;
            RGN_CART:         cpu_rdata = cart_rdata;
            default:          cpu_rdata = '0;
        endcase
    end

    assign cart_addr  = cpu_addr;
    assign cart_sel   = (req.wr || req.rd) && (req.rgn == RGN_CART);
    assign cart_we    = req.wr && (req.rgn == RGN_CART);
    assign cart_wdata = cpu_wdata;
    assign nmi_out    = vid0[NMI_BIT] && blank_in;

    // R5: a cartridge read returns the cartridge bus in the next cycle
    assert_cart_read_R5: assert property (@(posedge clk) disable iff (rst)
        (cart_sel && !cart_we) |=> (cpu_rdata == cart_rdata));

    // R9: no cartridge access while stalled
    assert_cart_stalled_R9: assert property (@(posedge clk) disable iff (rst)
        cpu_stall |-> !cart_sel);

    // R10: interrupt request only during blanking
    assert_nmi_blank_R10: assert property (@(posedge clk) disable iff (rst)
        nmi_out |-> blank_in);

    // R11: outputs quiet in the first cycle after reset
    assert_reset_quiet_R11: assert property (@(posedge clk)
        $past(rst) |-> (!tx_valid && !cpu_stall && !nmi_out));

endmodule

// File: tb/bus_window_decoder_test.sv
module bus_window_decoder_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] cpu_addr = '0;
    logic        cpu_wr = 1'b0;
    logic        cpu_rd = 1'b0;
    logic [7:0]  cpu_wdata = '0;
    logic [7:0]  cpu_rdata;
    logic        cpu_stall;
    logic [15:0] cart_addr;
    logic        cart_sel;
    logic        cart_we;
    logic [7:0]  cart_wdata;
    logic [7:0]  cart_rdata = '0;
    logic        tx_valid;
    logic [7:0]  tx_data;
    logic        tx_ready = 1'b0;
    logic        blank_in = 1'b0;
    logic        nmi_out;

    always #10 clk = ~clk;

    bus_window_decoder uut (
        .clk(clk), .rst(rst),
        .cpu_addr(cpu_addr), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_stall(cpu_stall),
        .cart_addr(cart_addr), .cart_sel(cart_sel), .cart_we(cart_we),
        .cart_wdata(cart_wdata), .cart_rdata(cart_rdata),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
        .blank_in(blank_in), .nmi_out(nmi_out)
    );

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit finished = 0;

    // reference state
    int    m_ram [2048];
    int    m_vid [8];
    int    m_io  [24];
    int    m_bytes [$];
    int    m_rd_kind = 0;   // 0 none, 1 stored value, 2 cartridge
    int    m_rd_val  = 0;
    string m_rd_req  = "";

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s cycle %0d: actual %0h expected %0h", req, cyc, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 8; i++)  m_vid[i] = 0;
        for (int i = 0; i < 24; i++) m_io[i] = 0;
        m_bytes.delete();
        m_rd_kind = 0;
    endtask

    function automatic int region_of(input int a);
        if (a < 'h2000) return 0;
        if (a < 'h4000) return 1;
        if (a <= 'h4017) return 2;
        if (a < 'h4020) return 3;
        return 4;
    endfunction

    task automatic step(input bit w, input bit r, input int a, input int d,
                        input bit rdy, input bit blk);
        int  rg;
        bit  exp_stall, acc, exp_nmi;
        @(negedge clk);
        cyc++;
        cpu_wr = w; cpu_rd = r; cpu_addr = a[15:0]; cpu_wdata = d[7:0];
        tx_ready = rdy; blank_in = blk;
        cart_rdata = 8'((cyc * 37) ^ 8'h5A);
        #8;
        if (rst) begin
            model_reset();
        end else begin
            rg = region_of(a);
            exp_stall = ((m_bytes.size() + 1) / 2) >= 2;
            chk(cpu_stall === exp_stall, "R8", int'(cpu_stall), int'(exp_stall));
            chk(tx_valid === (m_bytes.size() > 0), "R6", int'(tx_valid), int'(m_bytes.size() > 0));
            if (m_bytes.size() > 0)
                chk(tx_data === 8'(m_bytes[0]), "R6/R7", int'(tx_data), m_bytes[0]);
            exp_nmi = m_vid[0][7] && blk;
            chk(nmi_out === exp_nmi, "R10", int'(nmi_out), int'(exp_nmi));
            acc = (w || r) && !exp_stall;
            chk(cart_sel === (acc && rg == 4), "R5/R9", int'(cart_sel), int'(acc && rg == 4));
            chk(cart_we === (acc && w && rg == 4), "R5", int'(cart_we), int'(acc && w && rg == 4));
            chk(cart_addr === a[15:0], "R5", int'(cart_addr), a);
            if (m_rd_kind == 1 && m_rd_val >= 0)
                chk(cpu_rdata === 8'(m_rd_val), m_rd_req, int'(cpu_rdata), m_rd_val);
            if (m_rd_kind == 2)
                chk(cpu_rdata === cart_rdata, "R5", int'(cpu_rdata), int'(cart_rdata));
            // state update for the coming edge
            if (m_bytes.size() > 0 && rdy) void'(m_bytes.pop_front());
            m_rd_kind = 0;
            if (acc && w) begin
                case (rg)
                    0: m_ram[a & 'h7FF] = d & 'hFF;
                    1: begin
                        m_vid[a & 7] = d & 'hFF;
                        m_bytes.push_back(a & 7);
                        m_bytes.push_back(d & 'hFF);
                    end
                    2: begin
                        m_io[a & 'h1F] = d & 'hFF;
                        if ((a & 'h1F) == 'h14 || (a & 'h1F) == 'h16 || (a & 'h1F) == 'h17) begin
                            m_bytes.push_back(a & 'hFF);
                            m_bytes.push_back(d & 'hFF);
                        end
                    end
                    default: ;
                endcase
            end else if (acc && r) begin
                m_rd_kind = 1;
                case (rg)
                    0: begin m_rd_val = m_ram[a & 'h7FF]; m_rd_req = "R1"; end
                    1: begin m_rd_val = m_vid[a & 7];     m_rd_req = "R2"; end
                    2: begin m_rd_val = m_io[a & 'h1F];   m_rd_req = "R3"; end
                    3: begin m_rd_val = 0;                m_rd_req = "R4"; end
                    default: m_rd_kind = 2;
                endcase
            end
        end
    endtask

    task automatic idle(input int n, input bit rdy);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, rdy, 0);
    endtask

    initial begin
        for (int i = 0; i < 2048; i++) m_ram[i] = -1;
        model_reset();
        rst = 1'b1;
        idle(3, 0);
        rst = 1'b0;
        // R11: quiet outputs after reset (also compared inside step)
        #1;
        chk(!tx_valid && !cpu_stall && !nmi_out, "R11", int'({tx_valid, cpu_stall, nmi_out}), 0);
        idle(1, 0);

        // R1: RAM mirrors and stack page
        step(1, 0, 'h0005, 'h11, 1, 0);
        step(0, 1, 'h0805, 0, 1, 0);
        step(1, 0, 'h01FF, 'h3C, 1, 0);
        step(0, 1, 'h19FF, 0, 1, 0);
        step(0, 1, 'h1005, 0, 1, 0);
        idle(1, 1);

        // R2: reset value, write, mirrored readback, forwarding
        step(0, 1, 'h2003, 0, 1, 0);
        step(1, 0, 'h2003, 'hA5, 1, 0);
        step(0, 1, 'h3FFB, 0, 1, 0);
        idle(3, 1);

        // R3 / R7: stored-only and forwarded I/O registers
        step(1, 0, 'h4000, 'h42, 1, 0);
        step(0, 1, 'h4000, 0, 1, 0);
        step(1, 0, 'h4016, 'h01, 1, 0);
        idle(3, 1);
        step(1, 0, 'h4014, 'h02, 1, 0);
        step(1, 0, 'h4015, 'h0F, 1, 0);
        idle(4, 1);

        // R4: gap locations hold nothing
        step(1, 0, 'h401A, 'h55, 1, 0);
        step(0, 1, 'h401A, 0, 1, 0);
        idle(1, 1);

        // R5: cartridge write and read
        step(1, 0, 'h8000, 'h99, 1, 0);
        step(0, 1, 'h8123, 0, 1, 0);
        idle(1, 1);

        // R8 / R9: queue fills, third write stalls and is dropped
        step(1, 0, 'h2000, 'h80, 0, 0);
        step(1, 0, 'h2001, 'h1E, 0, 0);
        step(1, 0, 'h2002, 'h77, 0, 0);
        step(1, 0, 'h2002, 'h77, 0, 0);
        step(0, 1, 'h8000, 0, 0, 0);
        idle(8, 1);
        step(0, 1, 'h2002, 0, 1, 0);
        idle(1, 1);

        // R10: interrupt enable with blanking
        step(0, 0, 0, 0, 1, 1);
        step(0, 0, 0, 0, 1, 0);
        step(1, 0, 'h2008, 'h00, 1, 1);
        step(0, 0, 0, 0, 1, 1);
        idle(3, 1);

        // mixed traffic
        for (int k = 0; k < 400; k++) begin
            int sel, a, op;
            sel = $urandom_range(0, 4);
            case (sel)
                0: a = ($urandom_range(0, 15)) | ($urandom_range(0, 3) << 11);
                1: a = 'h2000 + $urandom_range(0, 'h1FFF);
                2: a = 'h4000 + $urandom_range(0, 'h1F);
                3: a = 'h4014 + $urandom_range(0, 3);
                default: a = 'h4020 + $urandom_range(0, 'hBFDF);
            endcase
            op = $urandom_range(0, 2);
            step(op == 1, op == 2, a, $urandom_range(0, 255),
                 $urandom_range(0, 9) < 7, $urandom_range(0, 1) == 1);
        end
        idle(10, 1);

        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual running expected done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule